// File: doc/BRIEF.md
# SD Card Power Control Sequencer

This block owns the power state of an SD/MMC host port. Software writes a 2-bit power-control code. The block turns that code into output-enable and drive-level controls for the card clock pad, the command pad and every data pad. It also gates the card clock and produces the enable that lets the command and data state machines run.

Two states share the code 00 but drive the pads differently. The state left by a hardware reset releases every pad to high impedance. The power-off state that software selects drives every pad high. After power-on the card clock runs, but the state machines stay disabled until a fixed number of card clock cycles has been counted. The card clock is given to the block as a one-cycle tick per card clock period. The normal software order is power-cycle, then power-off, then power-on, with a delay of about a millisecond before power-on. Code 01 is reserved.

Top module: `sd_pwr_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid write, the field reads 00, every pad output enable is 0, every drive level is 0, and `ck_run`, `path_en` and `startup_done` are 0. Reset acts without waiting for a clock edge.
- R2: Writing code 10 selects power-cycle. The field reads 10, all pad output enables are 1, all drive levels are 0 and the card clock is stopped.
- R3: Writing code 00 selects power-off. The field reads 00, all pad output enables are 1, all drive levels are 1, and `ck_run` and `path_en` are 0.
- R4: Writing code 11 selects power-on. The field reads 11 and `ck_run` is 1. The clock pad is enabled with level 0. The command and data pads are released (output enable 0, level 1).
- R5: In power-on, `path_en` and `startup_done` rise only after STARTUP_CLKS (default 74) card clock ticks have been counted. A tick is counted at a clock edge where `ck_tick` is 1, starting with the first edge after power-on is entered. Cycles without a tick do not count.
- R6: A write of the reserved code 01 changes neither the field nor any pad control.
- R7: Leaving power-on clears `path_en` and `startup_done` at the next edge. Entering power-on again restarts the full tick count.
- R8: Writing 11 while already in power-on does not restart the count.
- R9: `dir_cmd` is 1 when the host drives the command pad and `dir_dat` is 1 when it drives the data pads. When `dir_pol` is 1, both outputs are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the power-control code |
| ctrl_wdata | input | 2 | Power-control code: 00 off, 10 cycle, 11 on, 01 reserved |
| dir_pol | input | 1 | Inverts the transceiver direction outputs |
| ck_tick | input | 1 | One pulse per card clock period |
| pwr_field | output | 2 | Current power-control code readback |
| pad_oe_ck | output | 1 | Card clock pad output enable |
| pad_lvl_ck | output | 1 | Card clock pad static level |
| pad_oe_cmd | output | 1 | Command pad output enable |
| pad_lvl_cmd | output | 1 | Command pad level |
| pad_oe_dat | output | DATA_W | Data pad output enables |
| pad_lvl_dat | output | DATA_W | Data pad levels |
| dir_cmd | output | 1 | Command transceiver direction |
| dir_dat | output | 1 | Data transceiver direction |
| ck_run | output | 1 | Card clock gate open |
| path_en | output | 1 | Enable for the command and data state machines |
| startup_done | output | 1 | Start-up clock window finished |

## Verification
The case that is hardest to reach from the ports is the difference between the post-reset state and power-off. Both read back 00 and are told apart only by the pad enables. The bench therefore pulses reset in the middle of power-on and checks the released pads before any write. It then writes 00 and checks that the pads become driven-high while the readback stays the same. The start-up window is probed on both sides of its last tick, once with a continuous tick and once with gaps in the tick. The count is also checked after an exit from power-on and a return, and after a repeated power-on write.

// File: rtl/sd_pwr_pkg.sv
package sd_pwr_pkg;
   typedef enum logic [1:0] {
      PS_RESET = 2'd0,
      PS_CYCLE = 2'd1,
      PS_OFF   = 2'd2,
      PS_ON    = 2'd3
   } pwr_state_e;

   localparam logic [1:0] CODE_OFF   = 2'b00;
   localparam logic [1:0] CODE_RSV   = 2'b01;
   localparam logic [1:0] CODE_CYCLE = 2'b10;
   localparam logic [1:0] CODE_ON    = 2'b11;

   function automatic logic [1:0] state_to_code(input pwr_state_e s);
      case (s)
         PS_CYCLE: state_to_code = CODE_CYCLE;
         PS_ON:    state_to_code = CODE_ON;
         default:  state_to_code = CODE_OFF;
      endcase
   endfunction
endpackage

// File: rtl/sd_pwr_fsm.sv
module sd_pwr_fsm
   import sd_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [1:0] wdata,
   output pwr_state_e state,
   output logic [1:0] field
);
   pwr_state_e state_nx;

   always_comb begin
      state_nx = state;
      if (we) begin
         case (wdata)
            CODE_OFF:   state_nx = PS_OFF;
            CODE_CYCLE: state_nx = PS_CYCLE;
            CODE_ON:    state_nx = PS_ON;
            default:    state_nx = state;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_RESET;
      else        state <= state_nx;
   end

   assign field = state_to_code(state);

   p_ignore_rsv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata == CODE_RSV) |=> $stable(field));
   p_off_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata == CODE_OFF) |=> (field == CODE_OFF));
endmodule

// File: rtl/sd_pwr_startup.sv
module sd_pwr_startup #(
   parameter int STARTUP_CLKS = 74
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic done
);
   localparam int CNT_W = $clog2(STARTUP_CLKS + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STARTUP_CLKS);

   generate
      if (STARTUP_CLKS < 1) begin : g_bad_limit
         $error("STARTUP_CLKS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (!run)                 cnt <= '0;
      else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == LIMIT);

   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIMIT);
   p_done_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && $past(run)) |-> $past(tick));
endmodule

// File: rtl/sd_pwr_pads.sv
module sd_pwr_pads
   import sd_pwr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pwr_state_e        state,
   input  logic              dir_pol,
   output logic              oe_ck,
   output logic              lvl_ck,
   output logic              oe_cmd,
   output logic              lvl_cmd,
   output logic [DATA_W-1:0] oe_dat,
   output logic [DATA_W-1:0] lvl_dat,
   output logic              dir_cmd,
   output logic              dir_dat
);
   generate
      if (DATA_W != 1 && DATA_W != 4 && DATA_W != 8) begin : g_bad_width
         $error("DATA_W must be 1, 4 or 8");
      end
   endgenerate

   logic sig_oe, sig_lvl;

   always_comb begin
      case (state)
         PS_CYCLE: begin sig_oe = 1'b1; sig_lvl = 1'b0; end
         PS_OFF:   begin sig_oe = 1'b1; sig_lvl = 1'b1; end
         PS_ON:    begin sig_oe = 1'b0; sig_lvl = 1'b1; end
         default:  begin sig_oe = 1'b0; sig_lvl = 1'b0; end
      endcase
   end

   assign oe_ck   = (state != PS_RESET);
   assign lvl_ck  = (state == PS_OFF);
   assign oe_cmd  = sig_oe;
   assign lvl_cmd = sig_lvl;

   genvar i;
   generate
      for (i = 0; i < DATA_W; i++) begin : g_lane
         assign oe_dat[i]  = sig_oe;
         assign lvl_dat[i] = sig_lvl;
      end
   endgenerate

   assign dir_cmd = oe_cmd ^ dir_pol;
   assign dir_dat = (|oe_dat) ^ dir_pol;

   p_cycle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_CYCLE) |-> (oe_dat == '1 && lvl_dat == '0 && !lvl_ck));
endmodule

// File: rtl/sd_pwr_seq.sv
module sd_pwr_seq
   import sd_pwr_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int STARTUP_CLKS = 74
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [1:0]        ctrl_wdata,
   input  logic              dir_pol,
   input  logic              ck_tick,
   output logic [1:0]        pwr_field,
   output logic              pad_oe_ck,
   output logic              pad_lvl_ck,
   output logic              pad_oe_cmd,
   output logic              pad_lvl_cmd,
   output logic [DATA_W-1:0] pad_oe_dat,
   output logic [DATA_W-1:0] pad_lvl_dat,
   output logic              dir_cmd,
   output logic              dir_dat,
   output logic              ck_run,
   output logic              path_en,
   output logic              startup_done
);
   pwr_state_e st;
   logic       win_done;

   sd_pwr_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
      .state(st), .field(pwr_field)
   );

   sd_pwr_startup #(.STARTUP_CLKS(STARTUP_CLKS)) u_startup (
      .clk(clk), .rst_n(rst_n), .run(st == PS_ON), .tick(ck_tick),
      .done(win_done)
   );

   sd_pwr_pads #(.DATA_W(DATA_W)) u_pads (
      .clk(clk), .rst_n(rst_n), .state(st), .dir_pol(dir_pol),
      .oe_ck(pad_oe_ck), .lvl_ck(pad_lvl_ck),
      .oe_cmd(pad_oe_cmd), .lvl_cmd(pad_lvl_cmd),
      .oe_dat(pad_oe_dat), .lvl_dat(pad_lvl_dat),
      .dir_cmd(dir_cmd), .dir_dat(dir_dat)
   );

   assign ck_run       = (st == PS_ON);
   assign startup_done = win_done;
   assign path_en      = win_done;

   p_ready_only_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      startup_done |-> (pwr_field == CODE_ON && ck_run));
   p_drop_on_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ck_run) && !ck_run) |-> !path_en);
   p_reset_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_RESET) |-> (!pad_oe_ck && !pad_oe_cmd && pad_oe_dat == '0));
endmodule

// File: tb/sd_pwr_seq_bench.sv
module sd_pwr_seq_bench;
   localparam int DW = 8;
   localparam int NSTART = 74;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctrl_we = 1'b0;
   logic [1:0] ctrl_wdata = 2'b00;
   logic dir_pol = 1'b0;
   logic ck_tick = 1'b1;
   logic [1:0] pwr_field;
   logic pad_oe_ck, pad_lvl_ck, pad_oe_cmd, pad_lvl_cmd;
   logic [DW-1:0] pad_oe_dat, pad_lvl_dat;
   logic dir_cmd, dir_dat, ck_run, path_en, startup_done;

   int checks = 0;
   int errors = 0;
   logic finished = 1'b0;

   always #10 clk = ~clk;

   sd_pwr_seq #(.DATA_W(DW), .STARTUP_CLKS(NSTART)) u_sd_pwr_seq (.*);

   // {wdata, field, oe_ck, oe_cmd, oe_dat, lvl_ck, lvl_cmd, lvl_dat, ck_run}
   localparam int NV = 7;
   localparam logic [10:0] VEC [NV] = '{
      11'b10_10_111_000_0,   // R2 cycle
      11'b00_00_111_111_0,   // R3 off
      11'b01_00_111_111_0,   // R6 reserved, stays off
      11'b11_11_100_011_1,   // R4 on
      11'b01_11_100_011_1,   // R6 reserved, stays on
      11'b10_10_111_000_0,   // R2 cycle again
      11'b00_00_111_111_0    // R3 off again
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] d);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
      @(negedge clk); ctrl_we = 1'b0;
   endtask

   task automatic pads_released(input string req);
      chk(req, {31'd0, pad_oe_ck}, 0);
      chk(req, {31'd0, pad_oe_cmd}, 0);
      chk(req, {24'd0, pad_oe_dat}, 0);
      chk(req, {24'd0, pad_lvl_dat}, 0);
      chk(req, {30'd0, pwr_field}, 0);
      chk(req, {29'd0, ck_run, path_en, startup_done}, 0);
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #5;
      pads_released("R1 in reset");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      pads_released("R1 after release");

      for (int k = 0; k < NV; k++) begin
         wr(VEC[k][10:9]);
         chk($sformatf("vec%0d R2/R3/R4/R6 field", k), {30'd0, pwr_field}, {30'd0, VEC[k][8:7]});
         chk($sformatf("vec%0d R2/R3/R4/R6 oe_ck", k), {31'd0, pad_oe_ck}, {31'd0, VEC[k][6]});
         chk($sformatf("vec%0d R2/R3/R4/R6 oe_cmd", k), {31'd0, pad_oe_cmd}, {31'd0, VEC[k][5]});
         chk($sformatf("vec%0d R2/R3/R4/R6 oe_dat", k), {24'd0, pad_oe_dat}, {24'd0, {DW{VEC[k][4]}}});
         chk($sformatf("vec%0d R2/R3/R4/R6 lvl_ck", k), {31'd0, pad_lvl_ck}, {31'd0, VEC[k][3]});
         chk($sformatf("vec%0d R2/R3/R4/R6 lvl_cmd", k), {31'd0, pad_lvl_cmd}, {31'd0, VEC[k][2]});
         chk($sformatf("vec%0d R2/R3/R4/R6 lvl_dat", k), {24'd0, pad_lvl_dat}, {24'd0, {DW{VEC[k][1]}}});
         chk($sformatf("vec%0d R2/R3/R4/R6 ck_run", k), {31'd0, ck_run}, {31'd0, VEC[k][0]});
      end

      // R5: continuous tick, boundary at the last tick
      ck_tick = 1'b1;
      wr(2'b11);
      repeat (NSTART - 1) @(negedge clk);
      chk("R5 one tick short", {30'd0, path_en, startup_done}, 0);
      @(negedge clk);
      chk("R5 window done", {30'd0, path_en, startup_done}, 3);

      // R8: repeated power-on write keeps the window finished
      wr(2'b11);
      chk("R8 no restart", {30'd0, path_en, startup_done}, 3);

      // R9: direction outputs and polarity
      chk("R9 dir on pol0", {30'd0, dir_cmd, dir_dat}, 0);
      dir_pol = 1'b1; #1;
      chk("R9 dir on pol1", {30'd0, dir_cmd, dir_dat}, 3);

      // R7: exit drops enable, re-entry restarts the count
      wr(2'b10);
      chk("R7 drop on exit", {30'd0, path_en, startup_done}, 0);
      chk("R9 dir cycle pol1", {30'd0, dir_cmd, dir_dat}, 0);
      dir_pol = 1'b0; #1;
      chk("R9 dir cycle pol0", {30'd0, dir_cmd, dir_dat}, 3);
      wr(2'b11);
      repeat (NSTART - 1) @(negedge clk);
      chk("R7 restart short", {31'd0, path_en}, 0);
      @(negedge clk);
      chk("R7 restart done", {31'd0, path_en}, 1);

      // R5: ticks on alternate cycles only
      wr(2'b00);
      ck_tick = 1'b0;
      wr(2'b11);
      for (int t = 0; t < NSTART - 1; t++) begin
         ck_tick = 1'b1; @(negedge clk);
         ck_tick = 1'b0; @(negedge clk);
      end
      chk("R5 gapped short", {31'd0, startup_done}, 0);
      repeat (3) @(negedge clk);
      chk("R5 no tick no count", {31'd0, startup_done}, 0);
      ck_tick = 1'b1; @(negedge clk);
      ck_tick = 1'b0;
      chk("R5 gapped done", {31'd0, startup_done}, 1);

      // R1: asynchronous reset in power-on, then reset state differs from off
      #3; rst_n = 1'b0; #1;
      pads_released("R1 async in on");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      pads_released("R1 reset state");
      wr(2'b00);
      chk("R3 off after reset field", {30'd0, pwr_field}, 0);
      chk("R3 off after reset oe", {24'd0, pad_oe_dat}, {24'd0, {DW{1'b1}}});
      chk("R3 off after reset lvl", {31'd0, pad_lvl_cmd}, 1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule